// File: doc/BRIEF.md
# Memory Protection Entry Configuration Bank

This block stores the settings of a parameterised set of physical memory protection entries. Each entry has a one-byte configuration field and a word address register. Software reaches them through a single-cycle, CSR-style port. Configuration bytes are packed several to one machine word. Address registers are reached one per index.

Every entry can be write-protected. An entry's own lock bit protects it. An entry is also protected when the entry above it is locked and uses top-of-range matching, because that upper entry takes its lower bound from this entry's address. Writes that hit a protected entry are dropped without any indication.

For every entry, the block predecodes the match region into an inclusive start and end byte address. It also keeps the number of entries whose matching is enabled. Both are held in registers, so a downstream permission checker can use them directly from the cycle after any write.

Top module: `pmp_cfg_bank`

## Requirements
- R1: A config byte has this layout: bit 7 is the lock, bits [4:3] are the match mode (0 OFF, 1 TOR, 2 NA4, 3 NAPOT) and bits [2:0] are the permissions. Config word n carries entry n*(XLEN/8)+k in byte k, with the lowest entry in the least significant byte. Bytes for entries at or beyond N read as zero and ignore writes.
- R2: Writing address index j < N stores the value, and a read of that index returns it. Index j >= N ignores writes and reads zero.
- R3: When an entry's own lock bit is set, writes to its config byte and its address register are discarded. The other bytes of the same config word are still written.
- R4: An entry is also locked when the next entry has its lock bit set and mode TOR. A locked next entry in any other mode does not lock it. The highest entry is locked only by its own bit.
- R5: With XLEN = 64, writes to odd-numbered config words are discarded.
- R6: In TOR mode the range runs from prev<<2 to (addr<<2)-1, both modulo 2^(XLEN+2). prev is the address of the entry below, or 0 for entry 0.
- R7: In NA4 mode the range runs from addr<<2 to (addr<<2)+3.
- R8: In NAPOT mode, let t be the number of trailing ones in addr. The range starts at addr with its low t bits cleared, shifted left by 2, and spans 2^(t+3) bytes. An all-ones addr gives 0 up to the maximum address.
- R9: In OFF mode the range is reported as 0 up to the maximum address (all ones).
- R10: The active count equals the number of entries whose mode is not OFF. It and all ranges reflect a write from the cycle after that write's clock edge.
- R11: After reset, all config bytes and address registers are zero and the active count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe |
| csr_addr_sel | input | 1 | 1 selects an address register, 0 selects a config word |
| csr_idx | input | IDX_W | Config word number or address register index |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the selected register (combinational) |
| entry_cfg | output | N*8 | Config byte of every entry, entry i at bits [8i+7:8i] |
| range_lo | output | N*(XLEN+2) | Decoded start byte address per entry |
| range_hi | output | N*(XLEN+2) | Decoded inclusive end byte address per entry |
| active_cnt | output | clog2(N+1) | Number of entries with mode not OFF |

## Verification
The main instance is built with N = 16 and XLEN = 32. This gives four full config words, address indices beyond the bank, and a top entry whose lock cannot be inherited. It also gives 34-bit byte addresses, where TOR wrap-around and the all-ones NAPOT case land on the full range. A second instance is built with XLEN = 64 and N = 12. It covers the eight-byte packing, the rule that discards writes to odd config words, and config words that cover only missing entries.

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank #(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_we,
  input  logic                        csr_addr_sel,
  input  logic [IDX_W-1:0]            csr_idx,
  input  logic [XLEN-1:0]             csr_wdata,
  output logic [XLEN-1:0]             csr_rdata,
  output logic [N*8-1:0]              entry_cfg,
  output logic [N*(XLEN+2)-1:0]       range_lo,
  output logic [N*(XLEN+2)-1:0]       range_hi,
  output logic [$clog2(N+1)-1:0]      active_cnt
);
  localparam int BPC   = XLEN / 8;
  localparam int BW    = XLEN + 2;
  localparam int CNT_W = $clog2(N + 1);

  logic [7:0]      cfg_q  [N];
  logic [XLEN-1:0] addr_q [N];
  logic [7:0]      cfg_d  [N];
  logic [XLEN-1:0] addr_d [N];
  logic [BW-1:0]   lo_q   [N];
  logic [BW-1:0]   hi_q   [N];
  logic [BW-1:0]   lo_d   [N];
  logic [BW-1:0]   hi_d   [N];
  logic [N-1:0]    locked, on_d, on_q;

  wire odd_word = (XLEN == 64) && csr_idx[0];
  wire cfg_wr   = csr_we && !csr_addr_sel && !odd_word;
  wire addr_wr  = csr_we && csr_addr_sel;

  function automatic logic [2*BW-1:0] decode(input logic [1:0] mode,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] prev);
    logic [XLEN-1:0] inc;
    logic [BW-1:0]   lo, hi;
    inc = a + {{(XLEN-1){1'b0}}, 1'b1};
    case (mode)
      2'd1: begin
        lo = {prev, 2'b00};
        hi = {a, 2'b00} - {{(BW-1){1'b0}}, 1'b1};
      end
      2'd2: begin
        lo = {a, 2'b00};
        hi = {a, 2'b11};
      end
      2'd3: begin
        lo = {a & inc, 2'b00};
        hi = {a & inc, 2'b00} | {a ^ inc, 2'b11};
      end
      default: begin
        lo = '0;
        hi = '1;
      end
    endcase
    return {lo, hi};
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic [XLEN-1:0] prev_d;

    if (i == N - 1) begin : g_top
      assign locked[i] = cfg_q[i][7];
    end else begin : g_mid
      assign locked[i] = cfg_q[i][7] || (cfg_q[i+1][7] && cfg_q[i+1][4:3] == 2'd1);
    end

    if (i == 0) begin : g_first
      assign prev_d = '0;
    end else begin : g_rest
      assign prev_d = addr_d[i-1];
    end

    wire cfg_hit  = cfg_wr && (int'(csr_idx) == i / BPC) && !locked[i];
    wire addr_hit = addr_wr && (int'(csr_idx) == i) && !locked[i];

    assign cfg_d[i]  = cfg_hit ? csr_wdata[(i % BPC)*8 +: 8] : cfg_q[i];
    assign addr_d[i] = addr_hit ? csr_wdata : addr_q[i];
    assign {lo_d[i], hi_d[i]} = decode(cfg_d[i][4:3], addr_d[i], prev_d);
    assign on_d[i] = cfg_d[i][4:3] != 2'd0;
    assign on_q[i] = cfg_q[i][4:3] != 2'd0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
        lo_q[i]   <= '0;
        hi_q[i]   <= '1;
      end else begin
        cfg_q[i]  <= cfg_d[i];
        addr_q[i] <= addr_d[i];
        lo_q[i]   <= lo_d[i];
        hi_q[i]   <= hi_d[i];
      end
    end

    assign entry_cfg[i*8 +: 8]  = cfg_q[i];
    assign range_lo[i*BW +: BW] = lo_q[i];
    assign range_hi[i*BW +: BW] = hi_q[i];

    // R3
    own_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i][7] |=> ($stable(cfg_q[i]) && $stable(addr_q[i])));

    if (i < N - 1) begin : g_inh_chk
      // R4
      inherit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i+1][7] && cfg_q[i+1][4:3] == 2'd1) |=> $stable(addr_q[i]));
    end

    // R7
    na4_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[i][4:3] == 2'd2) |-> ((hi_q[i] - lo_q[i]) == {{(BW-2){1'b0}}, 2'b11}));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) active_cnt <= '0;
    else        active_cnt <= CNT_W'($countones(on_d));
  end

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (csr_addr_sel) begin
        if (int'(csr_idx) == i) csr_rdata = addr_q[i];
      end else if (int'(csr_idx) == i / BPC) begin
        csr_rdata[(i % BPC)*8 +: 8] = cfg_q[i];
      end
    end
  end

  // R10
  count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_cnt == CNT_W'($countones(on_q)));

  // R2
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr_sel && int'(csr_idx) >= N) |-> (csr_rdata == '0));
endmodule

// File: tb/tb_pmp_cfg_bank.sv
`timescale 1ns/1ps
module tb_pmp_cfg_bank;
  localparam int N  = 16;
  localparam int BW = 34;
  localparam int NV = 19;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic we, sel;
  logic [5:0] idx;
  logic [31:0] wdata, rdata;
  logic [N*8-1:0] cfg_o;
  logic [N*BW-1:0] lo_o, hi_o;
  logic [4:0] cnt;

  logic we6, sel6;
  logic [5:0] idx6;
  logic [63:0] wdata6, rdata6;
  logic [12*8-1:0] cfg6;
  logic [12*66-1:0] lo6, hi6;
  logic [3:0] cnt6;

  int checks = 0;
  int errors = 0;

  pmp_cfg_bank #(.N(N), .XLEN(32), .IDX_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_addr_sel(sel), .csr_idx(idx),
    .csr_wdata(wdata), .csr_rdata(rdata), .entry_cfg(cfg_o),
    .range_lo(lo_o), .range_hi(hi_o), .active_cnt(cnt));

  pmp_cfg_bank #(.N(12), .XLEN(64), .IDX_W(6)) dut_x64 (
    .clk(clk), .rst_n(rst_n), .csr_we(we6), .csr_addr_sel(sel6), .csr_idx(idx6),
    .csr_wdata(wdata6), .csr_rdata(rdata6), .entry_cfg(cfg6),
    .range_lo(lo6), .range_hi(hi6), .active_cnt(cnt6));

  // {addr_sel, index, write data, expected read-back}
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'd0,  32'h0000_0100, 32'h0000_0100},
    {1'b1, 6'd1,  32'h0000_0200, 32'h0000_0200},
    {1'b1, 6'd2,  32'h0000_0300, 32'h0000_0300},
    {1'b1, 6'd3,  32'h0000_0FFF, 32'h0000_0FFF},
    {1'b0, 6'd0,  32'h1B11_0F00, 32'h1B11_0F00},
    {1'b1, 6'd20, 32'h0000_1234, 32'h0000_0000},
    {1'b0, 6'd4,  32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 6'd1,  32'h0000_8800, 32'h0000_8800},
    {1'b0, 6'd1,  32'h5A5A_5A5A, 32'h5A5A_8800},
    {1'b1, 6'd4,  32'h0000_0077, 32'h0000_0000},
    {1'b1, 6'd5,  32'h0000_0066, 32'h0000_0000},
    {1'b1, 6'd6,  32'h0000_0055, 32'h0000_0055},
    {1'b0, 6'd2,  32'h0000_9000, 32'h0000_9000},
    {1'b1, 6'd8,  32'h0000_00AB, 32'h0000_00AB},
    {1'b1, 6'd9,  32'h0000_0001, 32'h0000_0000},
    {1'b0, 6'd2,  32'h0018_1800, 32'h0018_9000},
    {1'b1, 6'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 6'd3,  32'h0800_0000, 32'h0800_0000},
    {1'b1, 6'd15, 32'h0000_0040, 32'h0000_0040}
  };
  localparam logic [23:0] TAG [NV] = '{
    "R2", "R2", "R2", "R2", "R1", "R2", "R1", "R1", "R3", "R4",
    "R3", "R2", "R1", "R4", "R3", "R3", "R2", "R1", "R4"
  };

  task automatic chk(input logic [23:0] tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [5:0] i, input logic [31:0] d);
    @(negedge clk);
    sel = s; idx = i; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic wr6(input logic s, input logic [5:0] i, input logic [63:0] d);
    @(negedge clk);
    sel6 = s; idx6 = i; wdata6 = d; we6 = 1'b1;
    @(negedge clk);
    we6 = 1'b0;
    #1;
  endtask

  function automatic logic [BW-1:0] lo_of(input int e);
    return lo_o[e*BW +: BW];
  endfunction
  function automatic logic [BW-1:0] hi_of(input int e);
    return hi_o[e*BW +: BW];
  endfunction

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; sel = 1'b0; idx = '0; wdata = '0;
    we6 = 1'b0; sel6 = 1'b0; idx6 = '0; wdata6 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R11 reset state
    chk("R11", {32'h0, rdata}, 64'h0);
    chk("R11", {59'h0, cnt}, 64'h0);
    chk("R11", {56'h0, cfg_o[7:0]}, 64'h0);
    chk("R9", {30'h0, hi_of(0)}, {30'h0, 34'h3_FFFF_FFFF});

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][70], VEC[k][69:64], VEC[k][63:32]);
      chk(TAG[k], {32'h0, rdata}, {32'h0, VEC[k][31:0]});
    end

    // Decoded ranges
    chk("R9", {30'h0, lo_of(0)}, 64'h0);
    chk("R9", {30'h0, hi_of(0)}, {30'h0, 34'h3_FFFF_FFFF});
    chk("R6", {30'h0, lo_of(1)}, 64'h400);
    chk("R6", {30'h0, hi_of(1)}, 64'h7FF);
    chk("R7", {30'h0, lo_of(2)}, 64'hC00);
    chk("R7", {30'h0, hi_of(2)}, 64'hC03);
    chk("R8", {30'h0, lo_of(3)}, 64'h0);
    chk("R8", {30'h0, hi_of(3)}, 64'h7FFF);
    chk("R8", {30'h0, lo_of(6)}, 64'h150);
    chk("R8", {30'h0, hi_of(6)}, 64'h15F);
    chk("R8", {30'h0, lo_of(7)}, 64'h0);
    chk("R8", {30'h0, hi_of(7)}, 64'h7);
    chk("R8", {30'h0, lo_of(10)}, 64'h0);
    chk("R8", {30'h0, hi_of(10)}, {30'h0, 34'h3_FFFF_FFFF});
    chk("R6", {30'h0, lo_of(15)}, 64'h0);
    chk("R6", {30'h0, hi_of(15)}, 64'hFF);
    chk("R6", {30'h0, hi_of(5)}, {30'h0, 34'h3_FFFF_FFFF});
    chk("R3", {56'h0, cfg_o[5*8 +: 8]}, 64'h88);
    chk("R10", {59'h0, cnt}, 64'd9);

    // R10 timing: count unchanged while the write is pending, updated after the edge
    @(negedge clk);
    sel = 1'b0; idx = 6'd3; wdata = 32'h0800_0008; we = 1'b1;
    #1;
    chk("R10", {59'h0, cnt}, 64'd9);
    @(negedge clk);
    we = 1'b0;
    #1;
    chk("R10", {59'h0, cnt}, 64'd10);
    chk("R6", {30'h0, hi_of(12)}, {30'h0, 34'h3_FFFF_FFFF});

    // Wide-word instance
    wr6(1'b0, 6'd0, 64'h0807_0605_0403_0201);
    chk("R1", rdata6, 64'h0807_0605_0403_0201);
    chk("R10", {60'h0, cnt6}, 64'd1);
    wr6(1'b0, 6'd1, 64'h0101_0101_0101_0101);
    chk("R5", rdata6, 64'h0);
    chk("R5", {32'h0, cfg6[95:64]}, 64'h0);
    wr6(1'b0, 6'd2, 64'h0000_0000_0000_0001);
    chk("R1", rdata6, 64'h0);
    wr6(1'b1, 6'd11, 64'h1234_5678_9ABC_DEF0);
    chk("R2", rdata6, 64'h1234_5678_9ABC_DEF0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule